// File: doc/BRIEF.md
# Five-Channel Timer Tick Generator

This block turns one base clock into five tick enables, one per channel of a PWM timer. Each tick lasts one base-clock cycle. Two 8-bit prescalers split the base rate. The first serves channels 0 and 1, the second serves channels 2, 3 and 4. After its group's prescaler, each channel has a 4-bit selector that picks either a power-of-two divide of the prescaled strobe or rising edges of an external tick input. Channels 0 and 1 watch external input 0, and channels 2 to 4 watch external input 1. The downstream channel counters use these enables in place of separate clocks.

Both configuration words are level inputs that the block registers every cycle. When a prescaler byte changes, that prescaler and the dividers of every channel in its group start again from zero, so the first tick after a change comes one full new period later. A change in a channel's selector restarts only that channel's divider. External inputs are asynchronous. Each one passes through a two-flop synchronizer and an edge detector, so one rising edge gives exactly one tick.

Top module: `pwm_tick_gen`

## Requirements
- R1: In reset all ticks are low and both prescaler values and all selectors are taken as zero. In the first cycle after reset every tick is low. With all-zero configuration every channel then ticks on every cycle.
- R2: Prescaler value P sits in `pre_cfg[7:0]` and drives channels 0 and 1. A divider channel in this group ticks once every (P+1)·2^e cycles.
- R3: The second prescaler sits in `pre_cfg[15:8]` and drives channels 2, 3 and 4. A change in one group's prescaler does not change the tick interval of the other group.
- R4: The selector of channel c is `mux_cfg[4c+3:4c]`. A selector code n that is not marked external divides by 2^e with e = n + DIV_BASE (DIV_BASE is 0 by default).
- R5: If n + DIV_BASE exceeds MAX_EXP (4 by default), e is clamped to MAX_EXP. With the defaults, code 4 and codes 6 to 15 all divide by 16.
- R6: A selector code whose bit is set in EXT_MASK makes the channel tick once per rising edge of its group's external input. By default only code 5 is marked. Each synchronized edge gives a single pulse one cycle wide.
- R7: Let E be the first clock edge that samples a new prescaler value P for a group. A channel in that group whose divide is D and whose selector is unchanged has no tick until edge E+(P+1)·D+1. Its first tick appears in the cycle after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pre_cfg | input | 16 | Prescaler values, group 0 in [7:0], group 1 in [15:8] |
| mux_cfg | input | 20 | Per-channel 4-bit selector, channel c at bits [4c+3:4c] |
| ext_tick_in | input | 2 | Asynchronous external tick inputs, one per group |
| tick | output | 5 | One-cycle tick enable per channel |

## Verification
The hardest case to reach is the restart boundary. A prescaler change must discard both the prescaler's partial count and a strobe that is already registered but not yet consumed by the dividers. From the ports this shows only as the exact cycle of the first tick. The stimulus first lets a group run steadily with a small prescaler and two different divides. It then changes the prescaler on a falling edge and counts clock edges up to the first tick of each channel, and any premature tick in that window counts as a miss. External mode is reached by switching selectors to the marked code while free-running edge generators with unequal half-periods drive both external inputs.

// File: rtl/pwm_tick_pkg.sv
package pwm_tick_pkg;

    localparam int NUM_GRP = 2;

    function automatic int unsigned clamp_exp(input int unsigned code,
                                              input int unsigned base,
                                              input int unsigned max_exp);
        int unsigned e;
        e = code + base;
        if (e > max_exp) e = max_exp;
        return e;
    endfunction

endpackage

// File: rtl/pwm_tick_prescale.sv
module pwm_tick_prescale #(
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] scale_in,
    output logic          strobe,
    output logic          restart
);

    typedef struct packed {
        logic [PW-1:0] scale;
        logic [PW-1:0] cnt;
        logic          stb;
    } pre_st_t;

    pre_st_t st_d, st_q;

    assign restart = (scale_in != st_q.scale);

    always_comb begin
        st_d       = st_q;
        st_d.scale = scale_in;
        st_d.stb   = 1'b0;
        if (restart) begin
            st_d.cnt = '0;
        end else if (st_q.cnt == st_q.scale) begin
            st_d.cnt = '0;
            st_d.stb = 1'b1;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign strobe = st_q.stb;

endmodule

// File: rtl/pwm_tick_extsync.sv
module pwm_tick_extsync #(
    parameter int SYNC_W = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic pulse
);

    typedef struct packed {
        logic [SYNC_W:0] chain;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d.chain = {st_q.chain[SYNC_W-1:0], async_in};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pulse = st_q.chain[SYNC_W-1] & ~st_q.chain[SYNC_W];

endmodule

// File: rtl/pwm_tick_divider.sv
module pwm_tick_divider
    import pwm_tick_pkg::*;
#(
    parameter int              MW       = 4,
    parameter int              DIV_BASE = 0,
    parameter int              MAX_EXP  = 4,
    parameter logic [2**MW-1:0] EXT_MASK = 16'h0020
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [MW-1:0] code_in,
    input  logic          pre_stb,
    input  logic          grp_restart,
    input  logic          ext_pulse,
    output logic          tick,
    output logic          is_ext
);

    localparam int CW = (MAX_EXP < 1) ? 1 : MAX_EXP;

    typedef struct packed {
        logic [MW-1:0] code;
        logic [CW-1:0] cnt;
        logic          tick;
    } div_st_t;

    div_st_t     st_d, st_q;
    int unsigned exp_sel;
    logic [CW-1:0] limit;

    assign is_ext = EXT_MASK[st_q.code];

    always_comb begin
        exp_sel = clamp_exp(int'(st_q.code), DIV_BASE, MAX_EXP);
        limit   = CW'((32'd1 << exp_sel) - 32'd1);
    end

    always_comb begin
        st_d      = st_q;
        st_d.code = code_in;
        st_d.tick = 1'b0;
        if ((code_in != st_q.code) || grp_restart) begin
            st_d.cnt = '0;
        end else if (is_ext) begin
            st_d.cnt  = '0;
            st_d.tick = ext_pulse;
        end else if (pre_stb) begin
            if (st_q.cnt == limit) begin
                st_d.cnt  = '0;
                st_d.tick = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick = st_q.tick;

endmodule

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen
    import pwm_tick_pkg::*;
#(
    parameter int               NUM_CH    = 5,
    parameter int               GRP_SPLIT = 2,
    parameter int               PW        = 8,
    parameter int               MW        = 4,
    parameter int               DIV_BASE  = 0,
    parameter int               MAX_EXP   = 4,
    parameter int               SYNC_W    = 2,
    parameter logic [2**MW-1:0] EXT_MASK  = 16'h0020
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_GRP*PW-1:0]  pre_cfg,
    input  logic [NUM_CH*MW-1:0]   mux_cfg,
    input  logic [NUM_GRP-1:0]     ext_tick_in,
    output logic [NUM_CH-1:0]      tick
);

    logic [NUM_GRP-1:0] pre_stb;
    logic [NUM_GRP-1:0] grp_restart;
    logic [NUM_GRP-1:0] ext_pulse;
    logic [NUM_CH-1:0]  ch_ext;

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        pwm_tick_prescale #(.PW(PW)) u_pre (
            .clk      (clk),
            .rst_n    (rst_n),
            .scale_in (pre_cfg[g*PW +: PW]),
            .strobe   (pre_stb[g]),
            .restart  (grp_restart[g])
        );
        pwm_tick_extsync #(.SYNC_W(SYNC_W)) u_sync (
            .clk      (clk),
            .rst_n    (rst_n),
            .async_in (ext_tick_in[g]),
            .pulse    (ext_pulse[g])
        );
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        localparam int GI = (c < GRP_SPLIT) ? 0 : 1;
        pwm_tick_divider #(
            .MW       (MW),
            .DIV_BASE (DIV_BASE),
            .MAX_EXP  (MAX_EXP),
            .EXT_MASK (EXT_MASK)
        ) u_div (
            .clk         (clk),
            .rst_n       (rst_n),
            .code_in     (mux_cfg[c*MW +: MW]),
            .pre_stb     (pre_stb[GI]),
            .grp_restart (grp_restart[GI]),
            .ext_pulse   (ext_pulse[GI]),
            .tick        (tick[c]),
            .is_ext      (ch_ext[c])
        );
    end

endmodule

// File: rtl/pwm_tick_gen_chk.sv
module pwm_tick_gen_chk #(
    parameter int NUM_CH    = 5,
    parameter int GRP_SPLIT = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_CH-1:0] tick,
    input logic [NUM_CH-1:0] ch_ext,
    input logic [1:0]        grp_restart,
    input logic [1:0]        pre_stb,
    input logic [1:0]        ext_pulse
);

    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (tick == '0)); // R1

    for (genvar g = 0; g < 2; g++) begin : g_grp_chk
        AST_EXT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
            ext_pulse[g] |=> !ext_pulse[g]); // R6
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch_chk
        localparam int GI = (c < GRP_SPLIT) ? 0 : 1;
        AST_RESTART_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
            (grp_restart[GI] && !ch_ext[c]) |=> !tick[c]); // R7
        AST_TICK_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
            tick[c] |-> $past(pre_stb[GI] || ext_pulse[GI])); // R2
    end

endmodule

bind pwm_tick_gen pwm_tick_gen_chk #(
    .NUM_CH    (NUM_CH),
    .GRP_SPLIT (GRP_SPLIT)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .ch_ext      (ch_ext),
    .grp_restart (grp_restart),
    .pre_stb     (pre_stb),
    .ext_pulse   (ext_pulse)
);

// File: tb/pwm_tick_gen_bench.sv
`timescale 1ns/1ps
module pwm_tick_gen_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] pre_cfg = '0;
    logic [19:0] mux_cfg = '0;
    logic [1:0]  ext_tick_in = '0;
    logic [4:0]  tick;

    always #2.5 clk = ~clk;

    pwm_tick_gen u_pwm_tick_gen (
        .clk         (clk),
        .rst_n       (rst_n),
        .pre_cfg     (pre_cfg),
        .mux_cfg     (mux_cfg),
        .ext_tick_in (ext_tick_in),
        .tick        (tick)
    );

    typedef struct {
        int    ch;
        int    exp_iv;
        string tag;
    } item_t;

    item_t  sb_q[$];
    bit     mon_busy = 1'b0;
    int     n_checks = 0;
    int     n_fails  = 0;
    longint cyc = 0;
    bit     ext_run[2];
    int     ext_half[2];
    int     ext_cnt[2];

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int period(input int p, input int code);
        int e;
        e = code;
        if (e > 4) e = 4;
        return (p + 1) << e;
    endfunction

    task automatic check(input string tag, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic push_iv(input int ch, input int exp_iv, input string tag);
        item_t it;
        it.ch = ch; it.exp_iv = exp_iv; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic wait_idle();
        while (sb_q.size() != 0 || mon_busy) @(negedge clk);
    endtask

    task automatic set_code(input int ch, input logic [3:0] code);
        @(negedge clk);
        mux_cfg[ch*4 +: 4] = code;
    endtask

    // External edge generators
    initial begin
        ext_run[0] = 0; ext_run[1] = 0;
        ext_cnt[0] = 0; ext_cnt[1] = 0;
        ext_half[0] = 7; ext_half[1] = 11;
        forever begin
            @(posedge clk); #1;
            for (int i = 0; i < 2; i++) begin
                ext_cnt[i]++;
                if (ext_run[i] && ext_cnt[i] >= ext_half[i]) begin
                    ext_tick_in[i] = ~ext_tick_in[i];
                    ext_cnt[i] = 0;
                end
            end
        end
    end

    // Monitor: measures tick spacing for each scoreboard item
    initial begin
        forever begin
            item_t  it;
            int     seen;
            longint t0;
            while (sb_q.size() == 0) @(negedge clk);
            mon_busy = 1'b1;
            it = sb_q.pop_front();
            seen = 0;
            t0 = 0;
            while (seen < 3) begin
                @(negedge clk);
                if (tick[it.ch]) begin
                    seen++;
                    if (seen == 2) t0 = cyc;
                    if (seen == 3)
                        check($sformatf("%s ch%0d interval", it.tag, it.ch),
                              int'(cyc - t0), it.exp_iv);
                end
            end
            mon_busy = 1'b0;
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    // Driver
    initial begin
        int f0, f1;
        repeat (4) @(posedge clk);
        check("R1 tick in reset", int'(tick), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 tick first cycle after reset", int'(tick), 0);

        // R1: all-zero configuration, every channel every cycle
        for (int c = 0; c < 5; c++) push_iv(c, 1, "R1");
        wait_idle();

        // R2/R4: group 0 prescaler 2, codes 1 and 3; group 1 untouched (R3)
        @(negedge clk);
        pre_cfg[7:0] = 8'd2;
        mux_cfg[3:0] = 4'd1;
        mux_cfg[7:4] = 4'd3;
        repeat (3) @(negedge clk);
        push_iv(0, period(2, 1), "R2 R4");
        push_iv(1, period(2, 3), "R2 R4");
        push_iv(2, 1, "R3 other group unchanged");
        wait_idle();

        // R3: group 1 prescaler 4, codes 0, 2, 4
        @(negedge clk);
        pre_cfg[15:8] = 8'd4;
        mux_cfg[11:8]  = 4'd0;
        mux_cfg[15:12] = 4'd2;
        mux_cfg[19:16] = 4'd4;
        repeat (3) @(negedge clk);
        push_iv(2, period(4, 0), "R3");
        push_iv(3, period(4, 2), "R3");
        push_iv(4, period(4, 4), "R3 R4");
        push_iv(0, period(2, 1), "R3 other group unchanged");
        wait_idle();

        // R5: codes beyond the divide range clamp to 16
        set_code(4, 4'd7);
        set_code(1, 4'd15);
        repeat (3) @(negedge clk);
        push_iv(4, period(4, 4), "R5 code7");
        push_iv(1, period(2, 4), "R5 code15");
        wait_idle();
        set_code(1, 4'd6);
        repeat (3) @(negedge clk);
        push_iv(1, 48, "R5 code6");
        wait_idle();

        // R6: external mode on channel 0 (input 0) and channel 3 (input 1)
        ext_run[0] = 1; ext_run[1] = 1;
        set_code(0, 4'd5);
        set_code(3, 4'd5);
        repeat (3) @(negedge clk);
        push_iv(0, 2 * ext_half[0], "R6 ext0");
        push_iv(3, 2 * ext_half[1], "R6 ext1");
        push_iv(1, 48, "R6 divider neighbour");
        wait_idle();
        ext_run[0] = 0; ext_run[1] = 0;

        // R7: restart latency after a prescaler change
        set_code(0, 4'd0);
        set_code(1, 4'd1);
        repeat (40) @(negedge clk);
        @(negedge clk);
        pre_cfg[7:0] = 8'd5;
        f0 = 0; f1 = 0;
        for (int k = 1; k <= 20; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (tick[0] && f0 == 0) f0 = k;
            if (tick[1] && f1 == 0) f1 = k;
        end
        check("R7 first tick ch0 edge count", f0, (5 + 1) * 1 + 2);
        check("R7 first tick ch1 edge count", f1, (5 + 1) * 2 + 2);
        push_iv(0, period(5, 0), "R7 steady");
        push_iv(1, period(5, 1), "R7 steady");
        wait_idle();

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule